// File: doc/BRIEF.md
# Trigger Pattern Sequencer and Recorder

This block is used to test trigger logic inside the system. It holds one pattern memory with one byte per clock period. The same memory serves two purposes. In play mode it replays stored bytes, one per clock, onto the pre-trigger and trigger lines that feed the trigger logic. This gives stimulus that repeats exactly from run to run, but only for synchronous signals. In record mode it captures the trigger system's outgoing lines on every clock, so that software can read the trace back and check it.

A run begins with a start pulse. The mode input selects play or record. The run ends on a stop pulse or when the last address has been handled. In both cases a done flag is raised and the final address handled is reported. The host loads and reads the memory through a simple request port, and it may do so only while no run is active. The depth is set by `ADDR_W`. Setting `ADDR_W` to 14 gives the full 16K-entry store. The default is smaller so that the block elaborates quickly.

The control state machine has three states. `ST_IDLE` allows host access and waits for a start. `ST_PLAY` reads one entry per clock and drives it out. `ST_SINK` writes one sample per clock. There are four transitions:
- `ST_IDLE` to `ST_PLAY` on start with mode 0.
- `ST_IDLE` to `ST_SINK` on start with mode 1.
- `ST_PLAY` to `ST_IDLE` on stop, or when the entry at the last address is handled.
- `ST_SINK` to `ST_IDLE` on stop, or when the sample at the last address is handled.

Top module: `trig_seq`

## Requirements
- R1: After reset `busy`, `done` and `host_rvalid` are 0, `play_out` is 0 and `last_addr` is 0.
- R2: While idle, a host request with `host_en`=1 and `host_wr`=1 stores `host_wdata` at `host_addr`. A request with `host_en`=1 and `host_wr`=0 returns the stored byte on `host_rdata` with `host_rvalid`=1 in the cycle after the request edge.
- R3: A start pulse with `cmd_mode`=0 begins play at address 0. The address advances by one per clock, and the entry at address k appears on `play_out` in the cycle after the (k+2)-th rising edge counted from the start edge.
- R4: `play_out` is 0 whenever the block is not playing: while idle (apart from the single cycle that shows the final entry) and throughout a record run.
- R5: A start pulse with `cmd_mode`=1 begins recording. The value on `sink_in` at the j-th rising edge after the start edge is stored at address j-1.
- R6: A stop pulse during a run lets the entry or sample at the current address be handled on that edge. The run then returns to idle with `done`=1, and `last_addr` equals that address.
- R7: A run that reaches address 2^ADDR_W-1 ends by itself after that address is handled, with `done`=1 and `last_addr`=2^ADDR_W-1.
- R8: Host requests made during a run are ignored. Writes leave the memory unchanged, and reads give no `host_rvalid`.
- R9: A start pulse during a run is ignored, and so is a stop pulse while idle. A start accepted from idle clears `done` on the next edge.
- R10: `busy` is 1 from the edge after the start edge up to and including the edge that ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, accepted only while idle |
| cmd_stop | input | 1 | Stop pulse, acted on only during a run |
| cmd_mode | input | 1 | Run mode sampled with start: 0 play, 1 record |
| sink_in | input | DATA_W | Outgoing trigger lines to be recorded |
| play_out | output | DATA_W | Replayed pre-trigger and trigger lines |
| host_en | input | 1 | Host request valid |
| host_wr | input | 1 | Host request is a write when 1 |
| host_addr | input | ADDR_W | Host memory address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| busy | output | 1 | A run is active |
| done | output | 1 | The last run has ended |
| last_addr | output | ADDR_W | Address handled on the final edge of the last run |

## Verification
The assertions assume that `cmd_start` and `cmd_stop` are synchronous single-cycle pulses. They also assume the host raises requests only for single cycles, and that the memory was loaded before any play run that the bench compares against. The bench drives every input on the falling edge and holds each pulse for exactly one clock. It fills the whole memory with a computed pattern before the first play run and keeps record runs short. As a result, addresses outside the recorded window still hold known values when host writes during a run are checked as ignored.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAY = 2'd1,
        ST_SINK = 2'd2
    } run_state_t;

    localparam logic MODE_PLAY = 1'b0;
    localparam logic MODE_SINK = 1'b1;

endpackage

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              mode,
    output run_state_t        state,
    output logic [ADDR_W-1:0] ptr,
    output logic              done,
    output logic [ADDR_W-1:0] last_addr
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    run_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              done_q;
    logic [ADDR_W-1:0] last_q;
    logic              running;
    logic              run_end;

    assign running = (state_q != ST_IDLE);
    assign run_end = running && (stop || (ptr_q == TOP_ADDR));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (mode == MODE_SINK) ? ST_SINK : ST_PLAY;
                end
            end
            ST_PLAY, ST_SINK: begin
                if (run_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // run outputs: address pointer, completion flag, final address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
            last_q <= '0;
        end else if (!running) begin
            if (start) begin
                ptr_q  <= '0;
                done_q <= 1'b0;
            end
        end else if (run_end) begin
            done_q <= 1'b1;
            last_q <= ptr_q;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign state     = state_q;
    assign ptr       = ptr_q;
    assign done      = done_q;
    assign last_addr = last_q;

    // R3 / R5: one address per clock during a run
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop && ptr_q != TOP_ADDR) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R6 / R7: end of run reports the address and flags completion
    p_end_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (stop || ptr_q == TOP_ADDR)) |=>
            (done_q && last_q == $past(ptr_q) && state_q == ST_IDLE));

    // R9: accepted start clears done and begins at address zero
    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start) |=> (!done_q && ptr_q == '0 && state_q != ST_IDLE));

    // R9: start during a run does not restart the pointer
    p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !stop && ptr_q != TOP_ADDR) |=> (ptr_q != '0));

endmodule

// File: rtl/trig_seq_mem.sv
module trig_seq_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= store[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_mode,
    input  logic [DATA_W-1:0] sink_in,
    output logic [DATA_W-1:0] play_out,
    input  logic              host_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] last_addr
);

    run_state_t        state;
    logic [ADDR_W-1:0] ptr;
    logic              idle;
    logic              host_rd_ok;
    logic              host_wr_ok;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              play_vld_q;
    logic              rvalid_q;

    trig_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .stop      (cmd_stop),
        .mode      (cmd_mode),
        .state     (state),
        .ptr       (ptr),
        .done      (done),
        .last_addr (last_addr)
    );

    assign idle       = (state == ST_IDLE);
    assign host_wr_ok = idle && host_en && host_wr;
    assign host_rd_ok = idle && host_en && !host_wr;

    // memory port steering per state
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = host_addr;
        mem_wdata = host_wdata;
        mem_re    = 1'b0;
        mem_raddr = host_addr;
        unique case (state)
            ST_IDLE: begin
                mem_we = host_wr_ok;
                mem_re = host_rd_ok;
            end
            ST_PLAY: begin
                mem_re    = 1'b1;
                mem_raddr = ptr;
            end
            ST_SINK: begin
                mem_we    = 1'b1;
                mem_waddr = ptr;
                mem_wdata = sink_in;
            end
            default: begin
                mem_we = 1'b0;
                mem_re = 1'b0;
            end
        endcase
    end

    trig_seq_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_vld_q <= 1'b0;
            rvalid_q   <= 1'b0;
        end else begin
            play_vld_q <= (state == ST_PLAY);
            rvalid_q   <= host_rd_ok;
        end
    end

    assign play_out    = play_vld_q ? mem_rdata : '0;
    assign host_rdata  = mem_rdata;
    assign host_rvalid = rvalid_q;
    assign busy        = !idle;

    // R4: outputs stay quiet once idle has lasted more than a cycle
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (play_out == '0));

    // R4: a record run never drives the replay lines
    p_quiet_sink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINK) |=> (play_out == '0));

    // R8: host reads during a run return nothing
    p_run_read_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_en) |=> !host_rvalid);

    // R2: an idle read request is answered one cycle later
    p_read_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_en && !host_wr) |=> host_rvalid);

endmodule

// File: tb/trig_seq_test.sv
module trig_seq_test;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic          cmd_start;
    logic          cmd_stop;
    logic          cmd_mode;
    logic [DW-1:0] sink_in;
    logic [DW-1:0] play_out;
    logic          host_en;
    logic          host_wr;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid;
    logic          busy;
    logic          done;
    logic [AW-1:0] last_addr;

    int checks = 0;
    int errors = 0;

    trig_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .cmd_mode    (cmd_mode),
        .sink_in     (sink_in),
        .play_out    (play_out),
        .host_en     (host_en),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .busy        (busy),
        .done        (done),
        .last_addr   (last_addr)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [DW-1:0] fill_pat(input int a);
        return 8'((a * 7 + 90) & 255);
    endfunction

    function automatic logic [DW-1:0] rec_pat(input int j);
        return 8'(((j * 13 + 3) & 255) ^ 8'hC3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] d);
        host_en = 1'b1; host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [DW-1:0] d, output logic v);
        host_en = 1'b1; host_wr = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
        v = host_rvalid;
    endtask

    // leaves start asserted for exactly one edge; returns at the negedge after it
    task automatic pulse_start(input logic m);
        cmd_start = 1'b1; cmd_mode = m;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(host_rvalid == 1'b0, "R1 rvalid", host_rvalid, 0);
        chk(play_out == '0, "R1 play_out", play_out, 0);
        chk(last_addr == '0, "R1 last_addr", last_addr, 0);
    endtask

    task automatic t_host_fill();
        logic [DW-1:0] d;
        logic v;
        for (int a = 0; a < DEPTH; a++) host_write(a, fill_pat(a));
        for (int a = 0; a < 5; a++) begin
            host_read(a * 200, d, v);
            chk(v == 1'b1, "R2 rvalid", v, 1);
            chk(d == fill_pat(a * 200), "R2 rdata", d, fill_pat(a * 200));
        end
        host_read(DEPTH - 1, d, v);
        chk(d == fill_pat(DEPTH - 1), "R2 rdata top", d, fill_pat(DEPTH - 1));
        @(negedge clk);
        chk(host_rvalid == 1'b0, "R2 rvalid drops", host_rvalid, 0);
        chk(play_out == '0, "R4 idle after host reads", play_out, 0);
    endtask

    task automatic t_play_full();
        int bad = 0;
        pulse_start(1'b0);
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        chk(play_out == '0, "R3 nothing before first read", play_out, 0);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            if (play_out != fill_pat(k)) begin
                bad++;
                if (bad < 4) chk(1'b0, "R3 play entry", play_out, fill_pat(k));
            end
        end
        chk(bad == 0, "R3 all entries replayed", bad, 0);
        chk(done == 1'b1, "R7 done at end", done, 1);
        chk(busy == 1'b0, "R10 busy clear at end", busy, 0);
        chk(int'(last_addr) == DEPTH - 1, "R7 last_addr", last_addr, DEPTH - 1);
        @(negedge clk);
        chk(play_out == '0, "R4 quiet after play", play_out, 0);
    endtask

    task automatic t_play_stop(input int p);
        pulse_start(1'b0);
        chk(done == 1'b0, "R9 start clears done", done, 0);
        repeat (p) @(negedge clk);
        chk(busy == 1'b1, "R10 busy mid-run", busy, 1);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(play_out == fill_pat(p), "R6 entry on stop edge", play_out, fill_pat(p));
        chk(done == 1'b1, "R6 done after stop", done, 1);
        chk(int'(last_addr) == p, "R6 last_addr after stop", last_addr, p);
        chk(busy == 1'b0, "R10 busy clear after stop", busy, 0);
        @(negedge clk);
        chk(play_out == '0, "R4 quiet after stop", play_out, 0);
    endtask

    task automatic t_sink(input int n);
        logic [DW-1:0] d;
        logic v;
        int bad = 0;
        pulse_start(1'b1);
        for (int j = 0; j < n; j++) begin
            sink_in = rec_pat(j);
            if (j == 5) begin
                // host write and read during the run must be ignored (R8)
                host_en = 1'b1; host_wr = 1'b1; host_addr = AW'(900); host_wdata = 8'h00;
            end else if (j == 6) begin
                host_en = 1'b1; host_wr = 1'b0; host_addr = AW'(901);
            end else if (j == 7) begin
                host_en = 1'b0; host_wr = 1'b0;
                chk(host_rvalid == 1'b0, "R8 no rvalid during run", host_rvalid, 0);
                // start during run: mode change must have no effect (R9)
                cmd_start = 1'b1; cmd_mode = 1'b0;
            end else begin
                cmd_start = 1'b0;
            end
            if (j == n - 1) cmd_stop = 1'b1;
            @(negedge clk);
            if (play_out != '0) begin
                bad++;
            end
        end
        cmd_stop = 1'b0; cmd_start = 1'b0;
        chk(bad == 0, "R4 quiet during record", bad, 0);
        chk(done == 1'b1, "R6 done after record stop", done, 1);
        chk(int'(last_addr) == n - 1, "R6 record last_addr", last_addr, n - 1);
        chk(busy == 1'b0, "R9 restart ignored, run ended", busy, 0);
        bad = 0;
        for (int j = 0; j < n; j++) begin
            host_read(j, d, v);
            if (d != rec_pat(j)) begin
                bad++;
                if (bad < 4) chk(1'b0, "R5 recorded sample", d, rec_pat(j));
            end
        end
        chk(bad == 0, "R5 all samples recorded", bad, 0);
        host_read(n, d, v);
        chk(d == fill_pat(n), "R5 beyond window untouched", d, fill_pat(n));
        host_read(900, d, v);
        chk(d == fill_pat(900), "R8 write during run ignored", d, fill_pat(900));
    endtask

    task automatic t_idle_stop();
        logic [AW-1:0] prev;
        prev = last_addr;
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R9 idle stop keeps done", done, 1);
        chk(last_addr == prev, "R9 idle stop keeps last_addr", last_addr, prev);
        chk(busy == 1'b0, "R9 idle stop no run", busy, 0);
    endtask

    initial begin
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_mode = 1'b0;
        sink_in = '0; host_en = 1'b0; host_wr = 1'b0;
        host_addr = '0; host_wdata = '0; rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_fill();
        t_play_full();
        t_play_stop(37);
        t_play_stop(0);
        t_sink(24);
        t_idle_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule